// File: doc/BRIEF.md
# Configuration Packet Stream Parser

The parser accepts a stream of 32-bit configuration words and turns it into register-level events. While unsynchronised it throws away every word until the synchronisation pattern 0xAA995566 arrives. From then on it reads packet headers of two kinds. A short header names an opcode, a 5-bit register address and an 11-bit payload length. A long header carries only a 27-bit payload length and reuses the register and opcode of the most recent short header. The no-op word 0x20000000 may sit between packets and is consumed silently. Every payload word of a write packet is emitted as a one-cycle strobe. Words bound for the frame-data-input register go to a dedicated frame strobe, and all other registers use a generic register strobe that carries the address.

Writes to the frame-address register are split into their fields and held on output ports. Writes to the command register produce single-cycle pulses for CRC reset, startup and end-of-configuration. The end-of-configuration command also returns the parser to the unsynchronised state. Protocol violations set one sticky error flag, which only reset clears.

The input side is valid/ready. A word moves on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is held high from the first edge after reset, so the parser never applies back-pressure. The source may drop `in_valid` at any time with no effect on parser state. All outputs are registered and show the effect of an accepted word in the cycle after the edge that accepted it. The output strobes have no ready input, so consumers must take them as they come.

Top module: `cfg_stream_parser`

## Requirements
- R1: Before it sees 0xAA995566 the parser produces no strobe, no pulse and no error for any word, and `synced` stays 0. The cycle after that word is accepted, `synced` reads 1.
- R2: A 0x20000000 word received between packets causes no strobe, no pulse and no change of the error flag or of packet state.
- R3: A short header has bits [31:29]=001, opcode [28:27], register address [17:13] and payload length [10:0]. With opcode 10 (write), the next N accepted words each give one `reg_wr_valid` pulse carrying the address and the word. A length of 0 completes the packet at once, so the next word is decoded as a header.
- R4: A long header has bits [31:29]=010 and payload length [26:0]. It writes to the register and opcode of the preceding short header. A long header that arrives before any short header since synchronisation sets the error flag.
- R5: Payload words of packets with opcode 00 (no-op) or 01 (read) are consumed with no strobe. Opcode 11 sets the error flag, and the header is taken to have no payload.
- R6: Write payload words for register 00010 (frame data input) appear only on `frame_wr_valid`/`frame_wr_data` and never on `reg_wr_valid`.
- R7: A write header, short or long, that targets register 00010 with a length that is not a multiple of FRAME_WORDS (101) sets the error flag. Lengths that are a multiple, including 0, do not.
- R8: A write to register 00001 (frame address) updates `far_block`=[25:23], `far_top`=[22], `far_row`=[21:17], `far_col`=[16:7] and `far_minor`=[6:0] of the data word. No other word changes these outputs.
- R9: A write to register 00100 (command) with low 5 bits 00111 gives a one-cycle `crc_reset_pulse`, and with 00101 a one-cycle `start_pulse`.
- R10: Command value 01101 gives a one-cycle `desync_pulse`, and in that same cycle `synced` drops to 0. Later words are ignored as in R1 until the pattern arrives again.
- R11: `in_ready` is 1 from the first clock edge after reset. A word is taken only on an edge where `in_valid` is high, and idle cycles between words do not disturb a packet in progress.
- R12: `proto_err` is 0 after reset. It is set by any header in the header state whose bits [31:29] are neither 001 nor 010 (and which is not the no-op word), and by the cases in R4, R5 and R7. Once set it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input configuration word |
| in_ready | output | 1 | Parser can accept a word |
| synced | output | 1 | Synchronisation pattern seen and no end command since |
| reg_wr_valid | output | 1 | Register write strobe (not frame data) |
| reg_wr_addr | output | 5 | Register address of the write |
| reg_wr_data | output | 32 | Register write data |
| frame_wr_valid | output | 1 | Frame-data word strobe |
| frame_wr_data | output | 32 | Frame-data word |
| far_block | output | 3 | Frame address: block type |
| far_top | output | 1 | Frame address: top/bottom half |
| far_row | output | 5 | Frame address: row |
| far_col | output | 10 | Frame address: column |
| far_minor | output | 7 | Frame address: minor frame |
| crc_reset_pulse | output | 1 | CRC reset command pulse |
| start_pulse | output | 1 | Startup command pulse |
| desync_pulse | output | 1 | End-of-configuration command pulse |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The hardest state to reach from the ports is a long packet whose inherited target is the frame-data register. In that state the frame-multiple check has to use the remembered address, not a field of the current header. The stimulus reaches it by sending a zero-length short write header to that register and then long headers of 101 words and of 100 words. It counts every frame strobe across the 101-word payload and expects the error only for the 100-word header. A second hard path is resynchronisation after the end command. There the bench sends a complete write packet while unsynchronised, expects no strobe from it, then synchronises again and expects the next packet to decode normally.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [31:0] SYNC_WORD = 32'hAA995566;
  localparam logic [31:0] NOOP_WORD = 32'h20000000;

  localparam logic [2:0] HT_SHORT = 3'b001;
  localparam logic [2:0] HT_LONG  = 3'b010;

  localparam logic [1:0] OP_NOP  = 2'b00;
  localparam logic [1:0] OP_READ = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b10;
  localparam logic [1:0] OP_RSVD = 2'b11;

  localparam logic [4:0] RA_CRC  = 5'd0;
  localparam logic [4:0] RA_FAR  = 5'd1;
  localparam logic [4:0] RA_FDRI = 5'd2;
  localparam logic [4:0] RA_FDRO = 5'd3;
  localparam logic [4:0] RA_CMD  = 5'd4;

  localparam logic [4:0] CMD_CRC_RST = 5'b00111;
  localparam logic [4:0] CMD_START   = 5'b00101;
  localparam logic [4:0] CMD_DESYNC  = 5'b01101;

  typedef struct packed {
    logic [2:0] blk;
    logic       top;
    logic [4:0] row;
    logic [9:0] col;
    logic [6:0] minor;
  } far_t;

  typedef struct packed {
    logic        is_noop;
    logic        is_short;
    logic        is_long;
    logic [1:0]  op;
    logic [4:0]  addr;
    logic [26:0] len;
  } hdr_t;
endpackage

// File: rtl/cfgp_hdr_decode.sv
module cfgp_hdr_decode
  import cfgp_pkg::*;
(
  input  logic [31:0] word,
  output hdr_t        hdr
);
  always_comb begin
    hdr.is_noop  = (word == NOOP_WORD);
    hdr.is_short = (word[31:29] == HT_SHORT) && !hdr.is_noop;
    hdr.is_long  = (word[31:29] == HT_LONG);
    hdr.op       = word[28:27];
    hdr.addr     = word[17:13];
    hdr.len      = hdr.is_long ? word[26:0] : {16'd0, word[10:0]};
  end
endmodule

// File: rtl/cfgp_far_split.sv
module cfgp_far_split
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ld,
  input  logic [31:0] word,
  output far_t        far_q
);
  always_ff @(posedge clk) begin
    if (rst)     far_q <= '0;
    else if (ld) far_q <= far_t'(word[25:0]);
  end

  // R8
  far_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(far_q));
endmodule

// File: rtl/cfgp_cmd_decode.sv
module cfgp_cmd_decode
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [4:0] code,
  output logic       crc_rst_p,
  output logic       start_p,
  output logic       desync_p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      crc_rst_p <= 1'b0;
      start_p   <= 1'b0;
      desync_p  <= 1'b0;
    end else begin
      crc_rst_p <= ld && (code == CMD_CRC_RST);
      start_p   <= ld && (code == CMD_START);
      desync_p  <= ld && (code == CMD_DESYNC);
    end
  end

  // R9
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({crc_rst_p, start_p, desync_p}));
  // R9
  cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !start_p || $past(ld));
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfgp_pkg::*;
#(
  parameter int FRAME_WORDS = 101,
  parameter int LEN_W       = 27
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        synced,
  output logic        reg_wr_valid,
  output logic [4:0]  reg_wr_addr,
  output logic [31:0] reg_wr_data,
  output logic        frame_wr_valid,
  output logic [31:0] frame_wr_data,
  output logic [2:0]  far_block,
  output logic        far_top,
  output logic [4:0]  far_row,
  output logic [9:0]  far_col,
  output logic [6:0]  far_minor,
  output logic        crc_reset_pulse,
  output logic        start_pulse,
  output logic        desync_pulse,
  output logic        proto_err
);
  localparam logic [LEN_W-1:0] FRAME_LEN = LEN_W'(FRAME_WORDS);
  localparam logic [LEN_W-1:0] ONE_LEN   = LEN_W'(1);

  typedef enum logic [1:0] {ST_UNSYNC, ST_HDR, ST_DATA} st_t;

  st_t              st_q;
  logic [LEN_W-1:0] left_q;
  logic [4:0]       reg_q;
  logic [1:0]       op_q;
  logic             have_short_q;
  logic             rdy_q;
  hdr_t             hd;
  far_t             far_w;

  logic             take;
  logic             pay_wr;
  logic             far_ld;
  logic             cmd_ld;
  logic             desync_hit;
  logic [4:0]       tgt_reg;
  logic [1:0]       tgt_op;
  logic             frame_len_bad;

  cfgp_hdr_decode u_hdr (.word(in_data), .hdr(hd));

  assign take       = in_valid && rdy_q;
  assign pay_wr     = take && (st_q == ST_DATA) && (op_q == OP_WR);
  assign far_ld     = pay_wr && (reg_q == RA_FAR);
  assign cmd_ld     = pay_wr && (reg_q == RA_CMD);
  assign desync_hit = cmd_ld && (in_data[4:0] == CMD_DESYNC);

  always_comb begin
    tgt_reg = hd.is_short ? hd.addr : reg_q;
    tgt_op  = hd.is_short ? hd.op   : op_q;
    frame_len_bad = (tgt_reg == RA_FDRI) && (tgt_op == OP_WR) &&
                    ((hd.len[LEN_W-1:0] % FRAME_LEN) != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_UNSYNC;
      left_q         <= '0;
      reg_q          <= '0;
      op_q           <= OP_NOP;
      have_short_q   <= 1'b0;
      rdy_q          <= 1'b0;
      proto_err      <= 1'b0;
      reg_wr_valid   <= 1'b0;
      reg_wr_addr    <= '0;
      reg_wr_data    <= '0;
      frame_wr_valid <= 1'b0;
      frame_wr_data  <= '0;
    end else begin
      rdy_q          <= 1'b1;
      reg_wr_valid   <= 1'b0;
      frame_wr_valid <= 1'b0;
      if (take) begin
        unique case (st_q)
          ST_UNSYNC: begin
            if (in_data == SYNC_WORD) begin
              st_q         <= ST_HDR;
              have_short_q <= 1'b0;
            end
          end
          ST_HDR: begin
            if (hd.is_noop) begin
              st_q <= ST_HDR;
            end else if (hd.is_short) begin
              if (hd.op == OP_RSVD) begin
                proto_err <= 1'b1;
              end else begin
                reg_q        <= hd.addr;
                op_q         <= hd.op;
                have_short_q <= 1'b1;
                if (frame_len_bad) proto_err <= 1'b1;
                if (hd.len != '0) begin
                  left_q <= hd.len[LEN_W-1:0];
                  st_q   <= ST_DATA;
                end
              end
            end else if (hd.is_long) begin
              if (!have_short_q) begin
                proto_err <= 1'b1;
              end else begin
                if (frame_len_bad) proto_err <= 1'b1;
                if (hd.len != '0) begin
                  left_q <= hd.len[LEN_W-1:0];
                  st_q   <= ST_DATA;
                end
              end
            end else begin
              proto_err <= 1'b1;
            end
          end
          ST_DATA: begin
            left_q <= left_q - ONE_LEN;
            if (left_q == ONE_LEN) st_q <= ST_HDR;
            if (op_q == OP_WR) begin
              if (reg_q == RA_FDRI) begin
                frame_wr_valid <= 1'b1;
                frame_wr_data  <= in_data;
              end else begin
                reg_wr_valid <= 1'b1;
                reg_wr_addr  <= reg_q;
                reg_wr_data  <= in_data;
              end
            end
            if (desync_hit) begin
              st_q         <= ST_UNSYNC;
              have_short_q <= 1'b0;
            end
          end
          default: st_q <= ST_UNSYNC;
        endcase
      end
    end
  end

  cfgp_far_split u_far (
    .clk(clk), .rst(rst), .ld(far_ld), .word(in_data), .far_q(far_w)
  );

  cfgp_cmd_decode u_cmd (
    .clk(clk), .rst(rst), .ld(cmd_ld), .code(in_data[4:0]),
    .crc_rst_p(crc_reset_pulse), .start_p(start_pulse), .desync_p(desync_pulse)
  );

  assign in_ready  = rdy_q;
  assign synced    = (st_q != ST_UNSYNC);
  assign far_block = far_w.blk;
  assign far_top   = far_w.top;
  assign far_row   = far_w.row;
  assign far_col   = far_w.col;
  assign far_minor = far_w.minor;

  // R6
  frame_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_valid && frame_wr_valid));
  // R6
  frame_addr_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_valid |-> (reg_wr_addr != RA_FDRI));
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  // R10
  desync_drop_chk: assert property (@(posedge clk) disable iff (rst)
    desync_pulse |-> !synced);
  // R1
  unsync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !synced && !desync_pulse |-> !reg_wr_valid && !frame_wr_valid);
  // R11
  take_only_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !reg_wr_valid && !frame_wr_valid);
endmodule

// File: tb/sim_cfg_stream_parser.sv
`timescale 1ns/1ps
module sim_cfg_stream_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, synced, reg_wr_valid, frame_wr_valid;
  logic [4:0]  reg_wr_addr;
  logic [31:0] reg_wr_data, frame_wr_data;
  logic [2:0]  far_block;
  logic        far_top;
  logic [4:0]  far_row;
  logic [9:0]  far_col;
  logic [6:0]  far_minor;
  logic        crc_reset_pulse, start_pulse, desync_pulse, proto_err;

  int n_chk = 0;
  int n_bad = 0;
  int frames = 0;
  int regs = 0;

  always #2.5 clk = ~clk;

  cfg_stream_parser u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .synced(synced),
    .reg_wr_valid(reg_wr_valid), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .frame_wr_valid(frame_wr_valid), .frame_wr_data(frame_wr_data),
    .far_block(far_block), .far_top(far_top), .far_row(far_row),
    .far_col(far_col), .far_minor(far_minor),
    .crc_reset_pulse(crc_reset_pulse), .start_pulse(start_pulse),
    .desync_pulse(desync_pulse), .proto_err(proto_err)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        rv;
    logic        fv;
    logic [4:0]  addr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h00000001, 1'b0, 1'b0, 5'd0},
    '{32'hAA995566, 1'b0, 1'b0, 5'd0},
    '{32'h20000000, 1'b0, 1'b0, 5'd0},
    '{32'h30002001, 1'b0, 1'b0, 5'd0},
    '{32'h00C21A85, 1'b1, 1'b0, 5'd1},
    '{32'h30004000, 1'b0, 1'b0, 5'd0},
    '{32'h3000E002, 1'b0, 1'b0, 5'd0},
    '{32'h11111111, 1'b1, 1'b0, 5'd7},
    '{32'h22222222, 1'b1, 1'b0, 5'd7},
    '{32'h50000001, 1'b0, 1'b0, 5'd0},
    '{32'h33333333, 1'b1, 1'b0, 5'd7},
    '{32'h28006001, 1'b0, 1'b0, 5'd0},
    '{32'h44444444, 1'b0, 1'b0, 5'd0},
    '{32'h20000000, 1'b0, 1'b0, 5'd0}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (frame_wr_valid) frames++;
    if (reg_wr_valid) regs++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #900000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // reset state: R11 R12 R1
    chk(in_ready == 1'b1, "R11 ready after reset", 32'(in_ready), 1);
    chk(proto_err == 1'b0, "R12 err clear after reset", 32'(proto_err), 0);
    chk(synced == 1'b0, "R1 unsynced after reset", 32'(synced), 0);

    // table walk: R1 R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      send(VEC[i].word);
      chk(reg_wr_valid == VEC[i].rv, "R3 table reg strobe", 32'(reg_wr_valid), 32'(VEC[i].rv));
      chk(frame_wr_valid == VEC[i].fv, "R6 table frame strobe", 32'(frame_wr_valid), 32'(VEC[i].fv));
      if (VEC[i].rv) begin
        chk(reg_wr_addr == VEC[i].addr, "R4 table addr", 32'(reg_wr_addr), 32'(VEC[i].addr));
        chk(reg_wr_data == VEC[i].word, "R3 table data", reg_wr_data, VEC[i].word);
      end
      if (i == 1) chk(synced == 1'b1, "R1 synced after pattern", 32'(synced), 1);
    end
    chk(proto_err == 1'b0, "R2 no error from table", 32'(proto_err), 0);
    chk(far_block == 3'd1, "R8 block", 32'(far_block), 1);
    chk(far_top == 1'b1, "R8 top", 32'(far_top), 1);
    chk(far_row == 5'd1, "R8 row", 32'(far_row), 1);
    chk(far_col == 10'd53, "R8 col", 32'(far_col), 53);
    chk(far_minor == 7'd5, "R8 minor", 32'(far_minor), 5);

    // R11 idle gaps inside a packet
    send(32'h3000E001);
    repeat (3) @(negedge clk);
    chk(reg_wr_valid == 1'b0, "R11 no strobe while idle", 32'(reg_wr_valid), 0);
    send(32'h0BADF00D);
    chk(reg_wr_valid && reg_wr_data == 32'h0BADF00D, "R11 word after gap", reg_wr_data, 32'h0BADF00D);

    // R3 zero length completes at once
    send(32'h3000E000);
    send(32'h3000C001);
    send(32'h5A5A5A5A);
    chk(reg_wr_valid && reg_wr_addr == 5'd6, "R3 zero length then header", 32'(reg_wr_addr), 6);
    chk(proto_err == 1'b0, "R3 zero length no error", 32'(proto_err), 0);

    // R6 R7 frames via long header inheriting the frame register
    frames = 0;
    regs = 0;
    send(32'h30004000);
    send(32'h50000000 | 32'd101);
    chk(proto_err == 1'b0, "R7 multiple accepted", 32'(proto_err), 0);
    for (int k = 0; k < 101; k++) send(32'h1000 + 32'(k));
    chk(frames == 101, "R6 frame strobes", 32'(frames), 101);
    chk(regs == 0, "R6 no reg strobes", 32'(regs), 0);
    chk(frame_wr_data == 32'h1000 + 32'd100, "R6 last frame word", frame_wr_data, 32'h1064);
    send(32'h50000000 | 32'd100);
    chk(proto_err == 1'b1, "R7 long len 100 error", 32'(proto_err), 1);
    send(32'h20000000);
    chk(proto_err == 1'b1, "R12 error sticky", 32'(proto_err), 1);

    // R7 short header bad count
    do_reset();
    send(32'hAA995566);
    send(32'h30004005);
    chk(proto_err == 1'b1, "R7 short len 5 error", 32'(proto_err), 1);

    // R5 reserved opcode
    do_reset();
    send(32'hAA995566);
    send(32'h3800E001);
    chk(proto_err == 1'b1, "R5 reserved opcode", 32'(proto_err), 1);

    // R4 long header without short header
    do_reset();
    send(32'hAA995566);
    send(32'h50000001);
    chk(proto_err == 1'b1, "R4 orphan long header", 32'(proto_err), 1);

    // R12 unknown header type
    do_reset();
    send(32'hAA995566);
    send(32'h60000000);
    chk(proto_err == 1'b1, "R12 unknown header", 32'(proto_err), 1);

    // R9 R10 commands
    do_reset();
    send(32'hAA995566);
    send(32'h30008003);
    send(32'h00000007);
    chk(crc_reset_pulse == 1'b1 && start_pulse == 1'b0, "R9 crc reset pulse", 32'(crc_reset_pulse), 1);
    send(32'h00000005);
    chk(start_pulse == 1'b1 && crc_reset_pulse == 1'b0, "R9 start pulse", 32'(start_pulse), 1);
    send(32'h0000000D);
    chk(desync_pulse == 1'b1, "R10 desync pulse", 32'(desync_pulse), 1);
    chk(synced == 1'b0, "R10 synced drops", 32'(synced), 0);
    @(negedge clk);
    chk(desync_pulse == 1'b0, "R10 pulse one cycle", 32'(desync_pulse), 0);
    regs = 0;
    send(32'h3000E001);
    send(32'h77777777);
    chk(regs == 0 && proto_err == 1'b0, "R10 ignored after desync", 32'(regs), 0);
    send(32'hAA995566);
    send(32'h3000E001);
    send(32'h88888888);
    chk(reg_wr_valid && reg_wr_data == 32'h88888888, "R10 resync works", reg_wr_data, 32'h88888888);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule